// File: doc/BRIEF.md
# Serial Converter Input Register

This block is the digital front end of a 12-bit voltage-output converter. A host drives three wires into it: an active-low select, a serial clock and a serial data line. While select is low, each rising serial clock edge moves one bit into a 16-bit shift register, most significant bit first. Raising select copies the low 12 bits of that register into the converter code register, which is what the analog ladder downstream turns into a voltage.

A frame is 16 bits long: four filler bits followed by the 12 code bits. A lone device ignores the filler. In a chain, the oldest bit of the shift register leaves through a serial output that changes on the falling serial clock edge. Sending one frame per device in a single select window then lands each frame in the right device. The host-side wires are asynchronous to the block. They are sampled by a local system clock through synchronizer flops, and every edge is detected in that clock domain.

Top module: `sdac_input_reg`

## Requirements
- R1: While reset is high, and on the first cycle after it, the code output is zero, the update strobe is low and the serial output is low.
- R2: Each rising serial clock edge seen while select is low shifts the data line into bit 0 of the 16-bit shift register. The bits already held move one place towards bit 15, so the first bit sent ends up most significant.
- R3: On each rising edge of select, the code output takes shift register bits 11..0, with bit 11 as the code MSB.
- R4: The four filler bits (shift register bits 15..12) never affect the code output.
- R5: Serial clock edges while select is high do not change the shift register, so a following select pulse reloads the code already held.
- R6: There is no bit count. A select window with fewer than 16 clocks, or none, still loads the 12 low bits the register holds at that moment.
- R7: The update strobe is high for exactly one system clock per select rising edge, in the same cycle the new code first appears.
- R8: The serial output changes only after a falling serial clock edge, and then shows shift register bit 15. A frame sent into the register is therefore repeated on the serial output during the next 16 clocks.
- R9: The code output changes only in a cycle where the update strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial interface |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the host, asynchronous |
| csn_i | input | 1 | Active-low select from the host, asynchronous |
| sdi_i | input | 1 | Serial data from the host |
| dac_code_o | output | 12 | Code register driving the converter |
| update_o | output | 1 | One-cycle strobe marking a code load |
| sdo_o | output | 1 | Serial output for chaining to the next device |

## Verification
The bench builds the block with the default sizes: a 16-bit frame, a 12-bit code and two synchronizer stages. At these sizes the four filler bits are reachable, so a frame with a non-zero upper nibble shows they are dropped. Short and empty select windows can be made to reload a code that mixes bits from two frames. The serial clock half period of four system clocks is long enough for every edge to pass the synchronizers, so the chained output can be compared with a bench model of the register before every rising edge.

// File: rtl/sdac_pkg.sv
package sdac_pkg;
  // bit positions of the host wires in the synchronized vector
  localparam int SIG_SCLK  = 0;
  localparam int SIG_CSN   = 1;
  localparam int SIG_SDI   = 2;
  localparam int SIG_COUNT = 3;
  // synchronizer reset levels: select idles high, the rest low
  localparam logic [SIG_COUNT-1:0] SIG_IDLE = SIG_COUNT'(1) << SIG_CSN;
endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
  parameter int WIDTH = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[s] <= RST_VAL;
          else     stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_edge.sv
module sdac_edge #(
  parameter int WIDTH = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] level,
  output logic [WIDTH-1:0] rise,
  output logic [WIDTH-1:0] fall
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (rst) prev_q <= RST_VAL;
    else     prev_q <= level;
  end

  assign rise = level & ~prev_q;
  assign fall = ~level & prev_q;
endmodule

// File: rtl/sdac_shifter.sv
module sdac_shifter #(
  parameter int FRAME_W = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               shift_en,
  input  logic               din,
  input  logic               present,
  output logic [FRAME_W-1:0] shreg,
  output logic               sdo
);
  always_ff @(posedge clk) begin
    if (rst)           shreg <= '0;
    else if (shift_en) shreg <= {shreg[FRAME_W-2:0], din};
  end

  // chain output moves only on the falling serial edge
  always_ff @(posedge clk) begin
    if (rst)          sdo <= 1'b0;
    else if (present) sdo <= shreg[FRAME_W-1];
  end
endmodule

// File: rtl/sdac_input_reg.sv
module sdac_input_reg #(
  parameter int FRAME_W = 16,
  parameter int CODE_W = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_i,
  input  logic              csn_i,
  input  logic              sdi_i,
  output logic [CODE_W-1:0] dac_code_o,
  output logic              update_o,
  output logic              sdo_o
);
  import sdac_pkg::*;

  localparam int EDGE_W = 2;
  localparam logic [EDGE_W-1:0] EDGE_IDLE = SIG_IDLE[EDGE_W-1:0];

  logic [SIG_COUNT-1:0] raw_v, sync_v;
  logic [EDGE_W-1:0]    rise_v, fall_v;
  logic                 cs_idle, cs_rise, sclk_rise, sclk_fall, shift_en;
  logic                 edge_unused;
  logic [FRAME_W-1:0]   shreg_q;

  always_comb begin
    raw_v           = '0;
    raw_v[SIG_SCLK] = sclk_i;
    raw_v[SIG_CSN]  = csn_i;
    raw_v[SIG_SDI]  = sdi_i;
  end

  sdac_sync #(
    .WIDTH(SIG_COUNT), .STAGES(SYNC_STAGES), .RST_VAL(SIG_IDLE)
  ) u_sync (
    .clk(clk), .rst(rst), .d(raw_v), .q(sync_v)
  );

  sdac_edge #(
    .WIDTH(EDGE_W), .RST_VAL(EDGE_IDLE)
  ) u_edge (
    .clk(clk), .rst(rst), .level(sync_v[EDGE_W-1:0]),
    .rise(rise_v), .fall(fall_v)
  );

  assign cs_idle     = sync_v[SIG_CSN];
  assign cs_rise     = rise_v[SIG_CSN];
  assign sclk_rise   = rise_v[SIG_SCLK];
  assign sclk_fall   = fall_v[SIG_SCLK];
  assign edge_unused = fall_v[SIG_CSN];
  assign shift_en    = sclk_rise & ~cs_idle;

  sdac_shifter #(
    .FRAME_W(FRAME_W)
  ) u_shift (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(sync_v[SIG_SDI]),
    .present(sclk_fall), .shreg(shreg_q), .sdo(sdo_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_code_o <= '0;
      update_o   <= 1'b0;
    end else begin
      update_o <= cs_rise;
      if (cs_rise) dac_code_o <= shreg_q[CODE_W-1:0];
    end
  end
endmodule

// File: rtl/sdac_input_reg_chk.sv
module sdac_input_reg_chk #(
  parameter int FRAME_W = 16,
  parameter int CODE_W = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               cs_rise,
  input logic               cs_idle,
  input logic               sclk_fall,
  input logic [FRAME_W-1:0] shreg,
  input logic [CODE_W-1:0]  dac_code_o,
  input logic               update_o,
  input logic               sdo_o
);
  // R1
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (dac_code_o == '0 && !update_o && !sdo_o));
  // R3
  a_r3_load_lsbs: assert property (@(posedge clk) disable iff (rst)
    cs_rise |=> (update_o && dac_code_o == $past(shreg[CODE_W-1:0])));
  // R5
  a_r5_idle_hold: assert property (@(posedge clk) disable iff (rst)
    cs_idle |=> $stable(shreg));
  // R7
  a_r7_single_pulse: assert property (@(posedge clk) disable iff (rst)
    update_o |=> !update_o);
  // R8
  a_r8_sdo_on_fall: assert property (@(posedge clk) disable iff (rst)
    !sclk_fall |=> $stable(sdo_o));
  // R8
  a_r8_sdo_value: assert property (@(posedge clk) disable iff (rst)
    sclk_fall |=> (sdo_o == $past(shreg[FRAME_W-1])));
  // R9
  a_r9_code_hold: assert property (@(posedge clk) disable iff (rst)
    !update_o |-> $stable(dac_code_o));
endmodule

bind sdac_input_reg sdac_input_reg_chk #(
  .FRAME_W(FRAME_W), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rst(rst), .cs_rise(cs_rise), .cs_idle(cs_idle),
  .sclk_fall(sclk_fall), .shreg(shreg_q), .dac_code_o(dac_code_o),
  .update_o(update_o), .sdo_o(sdo_o)
);

// File: tb/sdac_input_reg_test.sv
module sdac_input_reg_test;
  localparam int FW = 16;
  localparam int CW = 12;
  localparam int HALF = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst = 1'b1, sclk = 1'b0, csn = 1'b1, sdi = 1'b0;
  logic [CW-1:0] dac_code;
  logic update, sdo;

  sdac_input_reg uut (
    .clk(clk), .rst(rst), .sclk_i(sclk), .csn_i(csn), .sdi_i(sdi),
    .dac_code_o(dac_code), .update_o(update), .sdo_o(sdo)
  );

  int checks = 0, fails = 0, pushed = 0, seen = 0;
  logic [FW-1:0] m_sh = '0;
  logic [CW-1:0] expq[$];
  logic prev_upd = 1'b0;
  logic [CW-1:0] last_code = '0;

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // driver: sends the n low bits of w, first bit most significant
  task automatic send(input logic [FW-1:0] w, input int n);
    csn = 1'b0;
    idle(HALF);
    for (int i = 0; i < n; i++) begin
      sdi = w[n-1-i];
      sclk = 1'b0;
      idle(HALF);
      check(sdo == m_sh[FW-1], "R8", "sdo before rise", sdo, m_sh[FW-1]);
      sclk = 1'b1;
      m_sh = {m_sh[FW-2:0], sdi};
      idle(HALF);
    end
    sclk = 1'b0;
    idle(HALF);
    check(sdo == m_sh[FW-1], "R8", "sdo at frame end", sdo, m_sh[FW-1]);
    csn = 1'b1;
    expq.push_back(m_sh[CW-1:0]);
    pushed++;
    idle(3*HALF);
  endtask

  // monitor: scoreboard against the expected load queue
  always @(negedge clk) begin
    if (!rst) begin
      if (update) begin
        seen++;
        check(!prev_upd, "R7", "strobe wider than one cycle", 1, 0);
        if (expq.size() == 0) begin
          check(1'b0, "R3", "unexpected load", dac_code, 0);
        end else begin
          logic [CW-1:0] e;
          e = expq.pop_front();
          check(dac_code == e, "R3", "loaded code", dac_code, e);
        end
      end else begin
        check(dac_code == last_code, "R9", "code moved without strobe",
              dac_code, last_code);
      end
      last_code = dac_code;
      prev_upd = update;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "R1", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(6);
    check(dac_code == '0, "R1", "code in reset", dac_code, 0);
    check(update == 1'b0, "R1", "strobe in reset", update, 0);
    rst = 1'b0;
    idle(1);
    check(dac_code == '0, "R1", "code after reset", dac_code, 0);
    check(sdo == 1'b0, "R1", "sdo after reset", sdo, 0);
    idle(10);
    check(update == 1'b0, "R1", "no load without select", update, 0);

    // R2: MSB first ordering
    send(16'h0801, 16);
    check(dac_code == 12'h801, "R2", "msb-first code", dac_code, 12'h801);
    send(16'h0ABC, 16);
    send(16'h0FFF, 16);
    send(16'h0000, 16);
    send(16'h5555, 16);

    // R4: filler bits dropped
    send(16'h7456, 16);
    check(dac_code == 12'h456, "R4", "filler 7 ignored", dac_code, 12'h456);
    send(16'hF123, 16);
    check(dac_code == 12'h123, "R4", "filler F ignored", dac_code, 12'h123);

    // R5: clocks with select high shift nothing
    sdi = 1'b1;
    for (int k = 0; k < 10; k++) begin
      sclk = 1'b1; idle(HALF);
      sclk = 1'b0; idle(HALF);
    end
    check(sdo == m_sh[FW-1], "R5", "sdo after idle clocks", sdo, m_sh[FW-1]);
    csn = 1'b0; idle(HALF);
    csn = 1'b1;
    expq.push_back(m_sh[CW-1:0]);
    pushed++;
    idle(3*HALF);
    check(dac_code == 12'h123, "R5", "reload after idle clocks",
          dac_code, 12'h123);

    // R6: short window mixes two frames
    send(16'h0ABC, 16);
    send(16'h00A5, 8);
    check(dac_code == 12'hCA5, "R6", "short frame code", dac_code, 12'hCA5);

    // R8: chained frame reappears on sdo during next frame
    send(16'h9C3E, 16);
    send(16'h0000, 16);
    check(m_sh == 16'h0000, "R8", "model drained", m_sh, 0);

    idle(20);
    check(expq.size() == 0, "R3", "loads outstanding", expq.size(), 0);
    check(seen == pushed, "R7", "strobe count", seen, pushed);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule